// File: doc/BRIEF.md
# Barrel Shifter with Carry and Overflow Flags

This block shifts a 32-bit word left or right by a variable amount and derives the carry and overflow flags a processor integer pipeline expects from such an operation. Two left selects (logical and arithmetic) behave the same way. Two right selects differ only in what enters at the top: zeros, or copies of the original sign bit. The count is trimmed to the bit width needed to address the word, so only amounts 0 to 31 ever take effect.

The carry output holds the last bit pushed past the word boundary. The overflow output is computed only for single-position shifts. A zero count leaves the word and both incoming flags untouched. For larger counts the incoming overflow passes through, and a qualifier output reports that the value carries no meaning. All outputs are registered, so results appear one clock after the inputs are presented.

Top module: `shift_flag_unit`

## Requirements
- R1: Only the low five bits of `count_i` set the shift amount. A count of 32 acts as 0, 33 acts as 1, and 63 acts as 31.
- R2: `op_i` encodes 0 = logical left, 1 = arithmetic left, 2 = logical right, 3 = arithmetic right. Selects 0 and 1 give identical outputs: bits move toward the MSB and zeros enter at bit 0.
- R3: A logical right shift fills the vacated upper bit positions with zeros.
- R4: An arithmetic right shift fills the vacated upper positions with bit 31 of the original operand. For example, 0xFFFFFFF7 (-9) shifted by 2 gives 0xFFFFFFFD (-3).
- R5: For a nonzero amount n, `carry_o` is original bit 32-n for left shifts and original bit n-1 for right shifts.
- R6: With a zero amount, `result_o` equals the operand, `carry_o` equals `carry_i`, `ovf_o` equals `ovf_i`, and `ovf_valid_o` is 1.
- R7: For a left shift by 1, `ovf_o` is the XOR of original bits 31 and 30.
- R8: For an arithmetic right shift by 1, `ovf_o` is 0.
- R9: For a logical right shift by 1, `ovf_o` equals original bit 31.
- R10: For amounts of 2 or more, `ovf_o` equals `ovf_i` and `ovf_valid_o` is 0. For amounts 0 and 1, `ovf_valid_o` is 1.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| operand_i | input | 32 | Word to shift |
| count_i | input | 8 | Shift count (only the low 5 bits count) |
| op_i | input | 2 | Shift type select |
| carry_i | input | 1 | Incoming carry flag |
| ovf_i | input | 1 | Incoming overflow flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | New carry flag |
| ovf_o | output | 1 | New overflow flag |
| ovf_valid_o | output | 1 | High when `ovf_o` has a defined meaning |

## Verification
Every output is recomputed from the inputs on each cycle, and only one output stage holds state. A bad value in a shifter stage, in the carry index or in the overflow selection therefore appears on the ports exactly one clock after the inputs that cause it. A wrong fill source shows up in the upper result bits of right shifts by large counts. An off-by-one in the carry index shows up at counts 1 and 31. Missed masking shows up as a count of 32 failing to behave like 0. The bench compares each result with a model that moves one bit per step, and it targets these counts on purpose.

// File: rtl/shift_flag_pkg.sv
package shift_flag_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_ASL = 2'b01,
        SH_LSR = 2'b10,
        SH_ASR = 2'b11
    } shift_op_e;

    function automatic logic op_is_left(input shift_op_e op);
        return (op == SH_LSL) || (op == SH_ASL);
    endfunction

    function automatic logic op_is_arith_right(input shift_op_e op);
        return op == SH_ASR;
    endfunction

endpackage

// File: rtl/shift_barrel.sv
module shift_barrel #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    input  logic          left_i,
    input  logic          fill_i,
    output logic [W-1:0]  data_o
);

    logic [W-1:0] pre_rev;
    logic [W-1:0] stage [SW+1];
    logic [W-1:0] post_rev;

    // reflect the word so that a single right-shifting network serves both directions
    for (genvar b = 0; b < W; b++) begin : g_rev_in
        assign pre_rev[b] = left_i ? data_i[W-1-b] : data_i[b];
    end

    assign stage[0] = pre_rev;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [W-1:0] shifted;
        assign shifted = {{STEP{fill_i}}, stage[k][W-1:STEP]};
        assign stage[k+1] = amt_i[k] ? shifted : stage[k];
    end

    assign post_rev = stage[SW];

    for (genvar b = 0; b < W; b++) begin : g_rev_out
        assign data_o[b] = left_i ? post_rev[W-1-b] : post_rev[b];
    end

endmodule

// File: rtl/shift_carry.sv
module shift_carry #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    input  logic          left_i,
    input  logic          carry_i,
    output logic          carry_o
);

    localparam logic [SW:0] WIDTH_V = (SW+1)'(W);
    localparam logic [SW:0] ONE_V   = (SW+1)'(1);

    logic [SW:0] idx;

    always_comb begin
        if (left_i) begin
            idx = WIDTH_V - {1'b0, amt_i};
        end else begin
            idx = {1'b0, amt_i} - ONE_V;
        end
        if (amt_i == '0) begin
            carry_o = carry_i;
        end else begin
            carry_o = data_i[idx[SW-1:0]];
        end
    end

endmodule

// File: rtl/shift_ovf.sv
module shift_ovf
    import shift_flag_pkg::*;
#(
    parameter int SW = 5
) (
    input  logic          top_i,
    input  logic          next_i,
    input  shift_op_e     op_i,
    input  logic [SW-1:0] amt_i,
    input  logic          ovf_i,
    output logic          ovf_o,
    output logic          valid_o
);

    always_comb begin
        ovf_o   = ovf_i;
        valid_o = 1'b1;
        if (amt_i == SW'(1)) begin
            unique case (op_i)
                SH_LSL, SH_ASL: ovf_o = top_i ^ next_i;
                SH_LSR:         ovf_o = top_i;
                SH_ASR:         ovf_o = 1'b0;
                default:        ovf_o = ovf_i;
            endcase
        end else if (amt_i != '0) begin
            valid_o = 1'b0;
        end
    end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
    import shift_flag_pkg::*;
#(
    parameter int W        = 32,
    parameter int CNT_IN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        operand_i,
    input  logic [CNT_IN_W-1:0] count_i,
    input  logic [1:0]          op_i,
    input  logic                carry_i,
    input  logic                ovf_i,
    output logic [W-1:0]        result_o,
    output logic                carry_o,
    output logic                ovf_o,
    output logic                ovf_valid_o
);

    localparam int SW = $clog2(W);
    localparam logic [CNT_IN_W-1:0] AMT_MASK = CNT_IN_W'(W - 1);

    typedef struct packed {
        logic [W-1:0] res;
        logic         cf;
        logic         of;
        logic         of_vld;
    } shift_out_t;

    shift_out_t out_d, out_q;

    shift_op_e     op;
    logic [SW-1:0] amt;
    logic          left;
    logic          fill;
    logic [W-1:0]  shifted;
    logic          cf_new;
    logic          of_new;
    logic          of_vld_new;

    assign op   = shift_op_e'(op_i);
    assign amt  = SW'(count_i & AMT_MASK);
    assign left = op_is_left(op);
    assign fill = op_is_arith_right(op) & operand_i[W-1];

    shift_barrel #(.W(W), .SW(SW)) u_barrel (
        .data_i (operand_i),
        .amt_i  (amt),
        .left_i (left),
        .fill_i (fill),
        .data_o (shifted)
    );

    shift_carry #(.W(W), .SW(SW)) u_carry (
        .data_i  (operand_i),
        .amt_i   (amt),
        .left_i  (left),
        .carry_i (carry_i),
        .carry_o (cf_new)
    );

    shift_ovf #(.SW(SW)) u_ovf (
        .top_i   (operand_i[W-1]),
        .next_i  (operand_i[W-2]),
        .op_i    (op),
        .amt_i   (amt),
        .ovf_i   (ovf_i),
        .ovf_o   (of_new),
        .valid_o (of_vld_new)
    );

    always_comb begin
        out_d        = out_q;
        out_d.res    = shifted;
        out_d.cf     = cf_new;
        out_d.of     = of_new;
        out_d.of_vld = of_vld_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o    = out_q.res;
    assign carry_o     = out_q.cf;
    assign ovf_o       = out_q.of;
    assign ovf_valid_o = out_q.of_vld;

endmodule

// File: rtl/shift_flag_unit_chk.sv
module shift_flag_unit_chk #(
    parameter int W        = 32,
    parameter int CNT_IN_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [W-1:0]        operand_i,
    input logic [CNT_IN_W-1:0] count_i,
    input logic [1:0]          op_i,
    input logic                carry_i,
    input logic                ovf_i,
    input logic [W-1:0]        result_o,
    input logic                carry_o,
    input logic                ovf_o,
    input logic                ovf_valid_o
);

    localparam int SW = $clog2(W);
    localparam logic [CNT_IN_W-1:0] AMT_MASK = CNT_IN_W'(W - 1);

    logic [SW-1:0] amt_c;
    assign amt_c = SW'(count_i & AMT_MASK);

    assert_zero_amt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_c == '0) |=> (result_o == $past(operand_i) && carry_o == $past(carry_i)
                           && ovf_o == $past(ovf_i) && ovf_valid_o));

    assert_left_one_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_c == SW'(1) && !op_i[1]) |=> (ovf_o == ($past(operand_i[W-1]) ^ $past(operand_i[W-2]))));

    assert_sar_one_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_c == SW'(1) && op_i == 2'b11) |=> !ovf_o);

    assert_shr_one_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_c == SW'(1) && op_i == 2'b10) |=> (ovf_o == $past(operand_i[W-1])));

    assert_big_amt_undef_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_c > SW'(1)) |=> (!ovf_valid_o && ovf_o == $past(ovf_i)));

    assert_left_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_c != '0 && !op_i[1]) |=> !result_o[0]);

    assert_shr_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_c != '0 && op_i == 2'b10) |=> !result_o[W-1]);

    assert_sar_sign_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b11) |=> (result_o[W-1] == $past(operand_i[W-1])));

endmodule

bind shift_flag_unit shift_flag_unit_chk #(.W(W), .CNT_IN_W(CNT_IN_W)) u_chk (.*);

// File: tb/tb_shift_flag_unit.sv
`timescale 1ns/1ps
module tb_shift_flag_unit;

    localparam int W = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  operand_i = '0;
    logic [CW-1:0] count_i = '0;
    logic [1:0]    op_i = '0;
    logic          carry_i = 1'b0;
    logic          ovf_i = 1'b0;
    logic [W-1:0]  result_o;
    logic          carry_o, ovf_o, ovf_valid_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    shift_flag_unit #(.W(W), .CNT_IN_W(CW)) dut (.*);

    // step-by-step model written from the requirements
    task automatic model(input logic [W-1:0] a, input logic [CW-1:0] c, input logic [1:0] op,
                         input logic cfi, input logic ofi,
                         output logic [W-1:0] r, output logic cf, output logic of, output logic vld);
        int n = int'(c) % 32;
        r = a; cf = cfi; of = ofi; vld = (n <= 1);
        for (int i = 0; i < n; i++) begin
            if (!op[1]) begin
                cf = r[W-1];
                r  = r << 1;
            end else begin
                cf = r[0];
                r  = {(op == 2'b11) ? a[W-1] : 1'b0, r[W-1:1]};
            end
        end
        if (n == 1) begin
            if (!op[1])          of = r[W-1] ^ cf;
            else if (op == 2'b10) of = a[W-1];
            else                  of = 1'b0;
        end
    endtask

    task automatic check(input string tag, input logic [W+2:0] act, input logic [W+2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [CW-1:0] c, input logic [1:0] op,
                         input logic cfi, input logic ofi);
        @(negedge clk);
        operand_i = a; count_i = c; op_i = op; carry_i = cfi; ovf_i = ofi;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_vs_model(input string tag, input logic [W-1:0] a, input logic [CW-1:0] c,
                                input logic [1:0] op, input logic cfi, input logic ofi);
        logic [W-1:0] r; logic cf, of, vld;
        model(a, c, op, cfi, ofi, r, cf, of, vld);
        apply(a, c, op, cfi, ofi);
        check(tag, {result_o, carry_o, ovf_o, ovf_valid_o}, {r, cf, of, vld});
    endtask

    task automatic t_reset();
        apply(32'hDEADBEEF, 8'd3, 2'b00, 1'b1, 1'b1);
        check("R11 reset", {result_o, carry_o, ovf_o, ovf_valid_o}, '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_latency();
        @(negedge clk);
        operand_i = 32'h0000_00F0; count_i = 8'd4; op_i = 2'b10; carry_i = 0; ovf_i = 0;
        @(posedge clk); #2;
        check("R11 one-cycle latency", {result_o, carry_o, ovf_o, ovf_valid_o},
              {32'h0000_000F, 1'b0, 1'b0, 1'b0});
    endtask

    task automatic t_mask();
        apply(32'h1234_5678, 8'd32, 2'b00, 1'b1, 1'b0);
        check("R1 count 32 acts as 0", {result_o, carry_o}, {32'h1234_5678, 1'b1});
        apply(32'h8000_0001, 8'd33, 2'b00, 1'b0, 1'b0);
        check("R1 count 33 acts as 1", {result_o, carry_o}, {32'h0000_0002, 1'b1});
        apply(32'h8000_0000, 8'd63, 2'b10, 1'b0, 1'b0);
        check("R1 count 63 acts as 31", {result_o, carry_o}, {32'h0000_0001, 1'b0});
    endtask

    task automatic t_left();
        logic [W+2:0] a0, a1;
        apply(32'hF0F0_1234, 8'd7, 2'b00, 1'b0, 1'b1);
        a0 = {result_o, carry_o, ovf_o, ovf_valid_o};
        apply(32'hF0F0_1234, 8'd7, 2'b01, 1'b0, 1'b1);
        a1 = {result_o, carry_o, ovf_o, ovf_valid_o};
        check("R2 select 0 equals select 1", a1, a0);
        check("R2 left zero fill", {35'(result_o)}, {35'(32'h7809_1A00)});
        check("R5 left carry bit 32-n", {34'b0, carry_o}, {34'b0, 1'b0});
        apply(32'h0000_0001, 8'd31, 2'b01, 1'b0, 1'b0);
        check("R5 left 31 carry bit 1", {result_o, carry_o}, {32'h8000_0000, 1'b0});
    endtask

    task automatic t_right();
        apply(32'hFFFF_0000, 8'd16, 2'b10, 1'b0, 1'b0);
        check("R3 logical right zero fill", {result_o, carry_o}, {32'h0000_FFFF, 1'b0});
        apply(32'hFFFF_FFF7, 8'd2, 2'b11, 1'b0, 1'b0);
        check("R4 -9 sar 2 is -3, R5 carry bit 1", {result_o, carry_o}, {32'hFFFF_FFFD, 1'b1});
        apply(32'h8000_0000, 8'd31, 2'b11, 1'b0, 1'b0);
        check("R4 sar 31 sign fill", {result_o, carry_o}, {32'hFFFF_FFFF, 1'b0});
        apply(32'h4000_0000, 8'd31, 2'b10, 1'b1, 1'b0);
        check("R5 right 31 carry bit 30", {result_o, carry_o}, {32'h0000_0000, 1'b1});
    endtask

    task automatic t_zero();
        apply(32'hCAFE_F00D, 8'd0, 2'b11, 1'b1, 1'b0);
        check("R6 zero amount passthrough", {result_o, carry_o, ovf_o, ovf_valid_o},
              {32'hCAFE_F00D, 1'b1, 1'b0, 1'b1});
        apply(32'hCAFE_F00D, 8'd0, 2'b00, 1'b0, 1'b1);
        check("R6 zero amount passthrough 2", {result_o, carry_o, ovf_o, ovf_valid_o},
              {32'hCAFE_F00D, 1'b0, 1'b1, 1'b1});
    endtask

    task automatic t_one_bit();
        apply(32'h8000_0001, 8'd1, 2'b00, 1'b0, 1'b0);
        check("R7 left ovf top bits differ", {result_o, carry_o, ovf_o, ovf_valid_o},
              {32'h0000_0002, 1'b1, 1'b1, 1'b1});
        apply(32'hC000_0000, 8'd1, 2'b01, 1'b0, 1'b1);
        check("R7 left ovf top bits equal", {33'b0, ovf_o, ovf_valid_o}, {33'b0, 1'b0, 1'b1});
        apply(32'h8000_0003, 8'd1, 2'b11, 1'b0, 1'b1);
        check("R8 sar one ovf clear", {result_o, carry_o, ovf_o, ovf_valid_o},
              {32'hC000_0001, 1'b1, 1'b0, 1'b1});
        apply(32'h8000_0000, 8'd1, 2'b10, 1'b1, 1'b0);
        check("R9 shr one ovf msb", {result_o, carry_o, ovf_o, ovf_valid_o},
              {32'h4000_0000, 1'b0, 1'b1, 1'b1});
    endtask

    task automatic t_big();
        apply(32'h8000_0000, 8'd5, 2'b10, 1'b0, 1'b1);
        check("R10 large amount ovf passthrough", {33'b0, ovf_o, ovf_valid_o}, {33'b0, 1'b1, 1'b0});
        apply(32'h4000_0000, 8'd2, 2'b00, 1'b0, 1'b0);
        check("R10 amount 2 ovf passthrough", {33'b0, ovf_o, ovf_valid_o}, {33'b0, 1'b0, 1'b0});
    endtask

    task automatic t_random();
        logic [CW-1:0] edges [4] = '{8'd0, 8'd1, 8'd31, 8'd32};
        for (int i = 0; i < 400; i++) begin
            logic [CW-1:0] c;
            c = (i % 2 == 0) ? edges[(i / 2) % 4] : CW'($urandom);
            run_vs_model("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random vs model",
                         $urandom, c, 2'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_latency();
        t_mask();
        t_left();
        t_right();
        t_zero();
        t_one_bit();
        t_big();
        t_random();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule